// File: doc/BRIEF.md
# 1-Wire Identifier Search Engine

This block walks the binary tree of 64-bit device identifiers on a 1-Wire bus and reports one identifier for each pass it is told to run. It does not time the bus itself. It asks its caller for three bit-level operations and waits for each to finish:

- a bus reset, which answers whether any device is present;
- a read slot, which answers with one bit;
- a write slot, which carries one bit.

The caller's reset operation also sends the search command byte, so the first read slot after a successful reset belongs to identifier bit 0.

Between passes the engine keeps the path it took last time and two branch markers. From these it decides which way to go at every bit where devices disagree. At the end of a pass it gives the identifier it found, a running count of valid identifiers and a status. The status says that more devices remain, that this was the last one, that a fault occurred, or that nobody answered the reset. A CRC-8 check over the whole identifier guards against corrupted reads.

Software or a small sequencer pulses `go` once per pass. It sets `fresh` on the first pass of a new enumeration, repeats while the status reads "more", and stops on any other status.

Top module: `owsr_search`

## Requirements
- R1: After an accepted `go`, the engine holds `bus_req` high and requests operations in a fixed order. It asks for one reset first. Then, for each identifier bit, it asks for a read, a second read and a write. The encoding of `bus_op` is 0 for reset, 1 for read and 2 for write. An operation completes in the cycle `bus_ack` is high.
- R2: A reset completion with `bus_rbit`=0 means no presence. It ends the pass with status 3 and `dev_count`=0.
- R3: For identifier bit i, the first read gives the true bit t and the second gives the complement c. If t=1 and c=0, the engine writes 1. If t=0 and c=1, it writes 0. The written value becomes bit i of `rom_id`, with bit 0 resolved first.
- R4: If t=1 and c=1, the pass ends at once with status 2. No further operation is requested.
- R5: On the first pass after a `fresh` start, every collision (t=0, c=0) takes the 0 branch.
- R6: Later passes choose collision directions from the previous path and the last and pending zero-branch markers. Successive passes therefore yield every device exactly once, in ascending order of the identifier read with bit 0 as the most significant digit.
- R7: A valid pass reports status 0 ("more") if it took a 0 branch at any collision. Otherwise it reports status 1 ("last").
- R8: Byte 7 of the identifier must equal the CRC-8 of bytes 0 to 6. The CRC uses the reflected polynomial 0x8C, initial value 0, and takes data LSB first. On a mismatch the pass reports status 2 and `dev_count` is not incremented.
- R9: A valid identifier increments `dev_count`, appears on `rom_id` and becomes the stored path for the next pass.
- R10: `go` with `fresh`=1 sets both markers to -1, clears the stored path and clears the count. `go` with `fresh`=0 continues from the stored state.
- R11: `done` is a one-cycle pulse at the end of each pass. A `go` that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start one search pass (pulse) |
| fresh | input | 1 | With `go`: begin a new enumeration |
| bus_req | output | 1 | A bus operation is requested |
| bus_op | output | 2 | Requested operation: 0 reset, 1 read, 2 write |
| bus_wbit | output | 1 | Bit to send in a write slot |
| bus_ack | input | 1 | Requested operation has completed |
| bus_rbit | input | 1 | Read bit, or presence on reset completion |
| done | output | 1 | Pass finished (one cycle) |
| status | output | 2 | 0 more, 1 last, 2 fault, 3 nobody present |
| rom_id | output | 64 | Identifier found by the pass |
| dev_count | output | 8 | Valid identifiers found since the fresh start |

## Verification
The hardest situation to reach is a later pass in which the pending zero-branch marker must fall back correctly. This needs three or more devices whose identifiers split at several depths, and at least two devices that differ only in bit 0 or only in a deep bit. The bench models a wired-AND bus of several devices with random payloads and valid CRC bytes, and it also places directed device pairs that collide at bit 0 and at bit 55. It then checks that each pass returns the next identifier in bit-0-first order. Faults are injected by muting every device partway through a pass and by corrupting a CRC byte. A stray `go` is also pulsed in the middle of a pass.

// File: rtl/owsr_pkg.sv
package owsr_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bus_op_t;

    typedef enum logic [1:0] {
        ST_MORE   = 2'd0,
        ST_LAST   = 2'd1,
        ST_FAULT  = 2'd2,
        ST_NOBODY = 2'd3
    } search_status_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_RDT,
        S_RDC,
        S_WR
    } walk_state_t;

    localparam logic [7:0] CRC_POLY = 8'h8C;

    // One LSB-first step of the reflected CRC-8.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/owsr_crc8.sv
module owsr_crc8 (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [7:0] crc
);
    import owsr_pkg::*;

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= 8'h00;
        else if (en)
            crc <= crc8_step(crc, din);
    end

endmodule

// File: rtl/owsr_branch.sv
module owsr_branch #(
    parameter int ID_W  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             coll,
    input  logic             commit,
    input  logic [IDX_W-1:0] idx,
    input  logic [ID_W-1:0]  path_in,
    output logic             choice,
    output logic             takes_zero
);
    localparam logic signed [IDX_W:0] NO_MARK = '1;

    logic signed [IDX_W:0] last_z;
    logic signed [IDX_W:0] prev_z;
    logic                  first;
    logic [ID_W-1:0]       path;
    logic signed [IDX_W:0] idx_s;

    assign idx_s = $signed({1'b0, idx});

    always_comb begin
        if (first) begin
            choice     = 1'b0;
            takes_zero = 1'b1;
        end else if (idx_s < last_z) begin
            choice     = path[idx];
            takes_zero = ~path[idx];
        end else if (idx_s == last_z) begin
            choice     = 1'b1;
            takes_zero = 1'b0;
        end else begin
            choice     = 1'b0;
            takes_zero = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            last_z <= NO_MARK;
            prev_z <= NO_MARK;
            first  <= 1'b1;
            path   <= '0;
        end else begin
            if (coll) begin
                if (first || idx_s > last_z) begin
                    prev_z <= last_z;
                    last_z <= idx_s;
                end else if (idx_s == last_z) begin
                    last_z <= prev_z;
                end else if (!path[idx]) begin
                    prev_z <= idx_s;
                end
            end
            if (commit) begin
                path  <= path_in;
                first <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/owsr_search.sv
module owsr_search #(
    parameter int ID_W  = 64,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             fresh,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic             bus_wbit,
    input  logic             bus_ack,
    input  logic             bus_rbit,
    output logic             done,
    output logic [1:0]       status,
    output logic [ID_W-1:0]  rom_id,
    output logic [CNT_W-1:0] dev_count
);
    import owsr_pkg::*;

    localparam int IDX_W = $clog2(ID_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

    walk_state_t    state;
    search_status_t status_q;
    logic [IDX_W-1:0] idx;
    logic tbit, took0, resolved;
    logic coll, crc_en, crc_clr, commit, br_init, br_choice, br_tz;
    logic [7:0] crc_q;
    bus_op_t op_c;

    assign coll    = (state == S_RDC) && bus_ack && !tbit && !bus_rbit;
    assign crc_en  = (state == S_RDC) && bus_ack && !(tbit && bus_rbit);
    assign crc_clr = (state == S_IDLE) && go;
    assign br_init = (state == S_IDLE) && go && fresh;
    assign commit  = (state == S_WR) && bus_ack && (idx == LAST_IDX) && (crc_q == 8'h00);

    always_comb begin
        unique case ({tbit, bus_rbit})
            2'b10:   resolved = 1'b1;
            2'b01:   resolved = 1'b0;
            2'b00:   resolved = br_choice;
            default: resolved = 1'b0;
        endcase
    end

    always_comb begin
        unique case (state)
            S_RST:   op_c = OP_RESET;
            S_WR:    op_c = OP_WRITE;
            default: op_c = OP_READ;
        endcase
    end

    assign bus_req = (state != S_IDLE);
    assign bus_op  = op_c;
    assign status  = status_q;

    owsr_crc8 u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(resolved), .crc(crc_q)
    );

    owsr_branch #(.ID_W(ID_W), .IDX_W(IDX_W)) u_branch (
        .clk(clk), .rst(rst), .init(br_init), .coll(coll), .commit(commit),
        .idx(idx), .path_in(rom_id), .choice(br_choice), .takes_zero(br_tz)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            status_q  <= ST_LAST;
            done      <= 1'b0;
            rom_id    <= '0;
            dev_count <= '0;
            idx       <= '0;
            tbit      <= 1'b0;
            took0     <= 1'b0;
            bus_wbit  <= 1'b1;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (go) begin
                    state  <= S_RST;
                    idx    <= '0;
                    took0  <= 1'b0;
                    rom_id <= '0;
                    if (fresh) dev_count <= '0;
                end
                S_RST: if (bus_ack) begin
                    if (bus_rbit) begin
                        state <= S_RDT;
                    end else begin
                        state     <= S_IDLE;
                        status_q  <= ST_NOBODY;
                        dev_count <= '0;
                        done      <= 1'b1;
                    end
                end
                S_RDT: if (bus_ack) begin
                    tbit  <= bus_rbit;
                    state <= S_RDC;
                end
                S_RDC: if (bus_ack) begin
                    if (tbit && bus_rbit) begin
                        state    <= S_IDLE;
                        status_q <= ST_FAULT;
                        done     <= 1'b1;
                    end else begin
                        bus_wbit    <= resolved;
                        rom_id[idx] <= resolved;
                        if (coll && br_tz) took0 <= 1'b1;
                        state <= S_WR;
                    end
                end
                S_WR: if (bus_ack) begin
                    if (idx == LAST_IDX) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                        if (crc_q != 8'h00) begin
                            status_q <= ST_FAULT;
                        end else begin
                            dev_count <= dev_count + 1'b1;
                            status_q  <= took0 ? ST_MORE : ST_LAST;
                        end
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_RDT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_fault_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_RDC && bus_ack && tbit && bus_rbit) |=> (done && status == ST_FAULT && !bus_req));

    p_absent_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_RST && bus_ack && !bus_rbit) |=> (done && status == ST_NOBODY && dev_count == '0));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_wait_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(idx) && $stable(bus_op)));

    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        (done && (status == ST_MORE || status == ST_LAST)) |-> (dev_count == CNT_W'($past(dev_count) + 1'b1)));

endmodule

// File: tb/owsr_search_test.sv
`timescale 1ns/1ps
module owsr_search_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0, fresh = 1'b0;
    logic bus_req, bus_wbit, done;
    logic [1:0] bus_op, status;
    logic bus_ack = 1'b0, bus_rbit = 1'b0;
    logic [63:0] rom_id;
    logic [7:0] dev_count;

    always #2.5 clk = ~clk;

    owsr_search uut (
        .clk(clk), .rst(rst), .go(go), .fresh(fresh),
        .bus_req(bus_req), .bus_op(bus_op), .bus_wbit(bus_wbit),
        .bus_ack(bus_ack), .bus_rbit(bus_rbit), .done(done),
        .status(status), .rom_id(rom_id), .dev_count(dev_count)
    );

    int errors = 0, checks = 0;
    logic [63:0] dev [8];
    logic act [8];
    int ndev = 0, pos = 0, seq = 0, op_count = 0, dly = 0;
    bit seq_bad = 0, kill_en = 0;
    int kill_pos = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    function automatic logic [7:0] crc_of(input logic [55:0] p);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ p[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    function automatic logic [63:0] rev64(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[63-i];
        return r;
    endfunction

    function automatic logic [63:0] mk(input logic [55:0] p);
        return {crc_of(p), p};
    endfunction

    function automatic logic [63:0] nth_expected(input int k);
        for (int i = 0; i < ndev; i++) begin
            int rank = 0;
            for (int j = 0; j < ndev; j++)
                if (rev64(dev[j]) < rev64(dev[i])) rank++;
            if (rank == k) return dev[i];
        end
        return '0;
    endfunction

    task automatic serve();
        logic b;
        op_count++;
        case (bus_op)
            2'd0: begin
                if (seq != 0) seq_bad = 1;
                for (int i = 0; i < 8; i++) act[i] = (i < ndev);
                pos = 0;
                bus_rbit = (ndev > 0);
                seq = 1;
            end
            2'd1: begin
                b = 1'b1;
                if (seq == 1) begin
                    for (int i = 0; i < ndev; i++) if (act[i]) b = b & dev[i][pos];
                    seq = 2;
                end else if (seq == 2) begin
                    for (int i = 0; i < ndev; i++) if (act[i]) b = b & ~dev[i][pos];
                    seq = 3;
                end else seq_bad = 1;
                bus_rbit = b;
            end
            default: begin
                if (seq != 3) seq_bad = 1;
                for (int i = 0; i < ndev; i++)
                    if (act[i] && dev[i][pos] != bus_wbit) act[i] = 0;
                if (kill_en && pos == kill_pos - 1)
                    for (int i = 0; i < 8; i++) act[i] = 0;
                pos++;
                seq = 1;
            end
        endcase
    endtask

    // bus responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req) begin
                if (dly > 0) dly--;
                else begin
                    serve();
                    bus_ack = 1'b1;
                    dly = $urandom_range(0, 3);
                end
            end
        end
    end

    task automatic run_pass(input bit f, input bit stray);
        int guard = 0;
        seq = 0; op_count = 0; seq_bad = 0;
        @(negedge clk); go = 1'b1; fresh = f;
        @(negedge clk); go = 1'b0; fresh = 1'b0;
        do begin
            @(negedge clk);
            guard++;
            if (stray && guard == 40) begin go = 1'b1; fresh = 1'b1; end
            else begin go = 1'b0; fresh = 1'b0; end
        end while (!done && guard < 5000);
        go = 1'b0; fresh = 1'b0;
    endtask

    task automatic enumerate(input int n, input bit stray);
        ndev = n;
        for (int k = 0; k < n; k++) begin
            logic [63:0] e = nth_expected(k);
            run_pass(k == 0, stray);
            chk(seq_bad == 0, "R1 op order", seq_bad, 0);
            if (k == 0) chk(rom_id == e, "R5 first id", rom_id, e);
            else chk(rom_id == e, "R6 next id", rom_id, e);
            chk(status == ((k < n - 1) ? 2'd0 : 2'd1), "R7 status", status, (k < n - 1) ? 0 : 1);
            chk(dev_count == 8'(k + 1), "R9 count", dev_count, k + 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !bus_req && dev_count == 0, "R11 reset state", {done, bus_req, dev_count}, 0);

        // nobody present
        ndev = 0;
        run_pass(1, 0);
        chk(status == 2'd3 && dev_count == 0, "R2 absent", {status, dev_count}, 64'h300);

        // single device: no collisions
        dev[0] = mk({$urandom, $urandom});
        enumerate(1, 0);
        chk(rom_id == dev[0], "R3 single id", rom_id, dev[0]);

        // pair colliding only at bit 0
        begin
            logic [55:0] p = {$urandom, $urandom};
            dev[0] = mk(p); dev[1] = mk(p ^ 56'h1);
            enumerate(2, 0);
            dev[0] = mk(p); dev[1] = mk(p ^ (56'h1 << 55));
            enumerate(2, 0);
        end

        // directed: four devices splitting at bits 0 and 1
        begin
            logic [55:0] p = {$urandom, $urandom} & ~56'h3;
            for (int i = 0; i < 4; i++) dev[i] = mk(p | 56'(i));
            enumerate(4, 0);
        end

        // random populations
        for (int r = 0; r < 6; r++) begin
            int n = $urandom_range(2, 7);
            for (int i = 0; i < n; i++) dev[i] = mk({$urandom, $urandom});
            enumerate(n, 0);
        end

        // stray go mid pass is ignored
        for (int i = 0; i < 3; i++) dev[i] = mk({$urandom, $urandom});
        enumerate(3, 1);
        chk(dev_count == 3, "R11 stray go ignored", dev_count, 3);

        // corrupted CRC byte
        ndev = 1;
        dev[0] = mk({$urandom, $urandom}) ^ (64'h5A << 56);
        run_pass(1, 0);
        chk(status == 2'd2, "R8 crc fault", status, 2);
        chk(dev_count == 0, "R8 count kept", dev_count, 0);

        // all devices vanish at bit 10
        ndev = 2;
        dev[0] = mk({$urandom, $urandom}); dev[1] = mk({$urandom, $urandom});
        kill_en = 1; kill_pos = 10;
        run_pass(1, 0);
        kill_en = 0;
        chk(status == 2'd2, "R4 both high fault", status, 2);
        chk(op_count == 1 + 3 * 10 + 2, "R4 no further ops", op_count, 33);

        // fresh restart after fault
        enumerate(2, 0);
        chk(dev_count == 2, "R10 fresh restart", dev_count, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule